// File: doc/BRIEF.md
# Three-Phase Triangle-Carrier PWM Modulator with Twin Update Points

The block turns three signed phase-voltage demands into gate drive for a two-level, three-leg inverter. Each demand is first corrected for DC-link ripple. It is multiplied by the ratio of the nominal DC-link voltage to the measured DC-link voltage, and the result is mapped onto the range of an up/down triangle counter. The mapped value is held in a per-phase shadow register. It moves into the active compare register only when the carrier sits at its valley (count zero) or at its peak. A leg is demanded high while its active compare value is above the carrier count.

A sample strobe marks both the valley and the peak. It runs at twice the switching rate, so the surrounding control loop can sample and compute once per carrier half-period. Each leg drives a complementary high-side/low-side pair. A programmable dead band holds both gates low after every change of demand. A demand pulse that is shorter than the dead band never turns a gate on.

The demand, DC-link and timing inputs are plain levels that the block samples on every clock. There is no handshake: a new demand takes effect at the next update point, and a value that is replaced before then is dropped without stalling anything. A synchronous reset, or deasserting the enable, forces all gates low and parks the carrier at the valley.

Top module: `dpwm_modulator`

## Requirements
- R1: With the enable high, the carrier counts up by one per clock from 0 to the peak P, then down by one per clock to 0, and repeats. P is `half_period`, or 1 when `half_period` is 0. While counting up, a count at or above P turns the carrier down. At 0 it turns up.
- R2: `sample_stb` is high in exactly those enabled, non-reset cycles in which the carrier equals 0 or P. This gives two strobes per carrier period.
- R3: The clock edge that ends a strobe cycle copies each shadow value into the active compare register. At no other edge does the active compare register change. The shadow register captures the mapped demand on every edge, so a demand that is replaced before the next update point has no effect on the gates.
- R4: Each demand `r` (12-bit two's complement, phase k in bits [12k+11:12k] of `vref`) is scaled to s = r*`vdc_ref`/`vdc_meas`, truncated toward zero. When `vdc_meas` is below VDC_MIN (default 64), which includes 0, s = r.
- R5: The mapped compare value is floor((s+2048)*P/4096), clamped to the range 0..P.
- R6: The demand of a leg is high when its active compare value is greater than the carrier count. In steady state `gate_hi` follows the demand and `gate_lo` follows its inverse, one clock later.
- R7: `gate_hi[k]` and `gate_lo[k]` are never high together. After a change of demand, both are low for exactly `dead_time`+1 clocks before the newly demanded gate turns on.
- R8: If the demand changes again before the dead band has expired, the dead band restarts and the gate of the short pulse never turns on.
- R9: While `rst` is high, or at the clock after `en` is sampled low, all gates are low and the carrier is 0. When `en` rises, the first enabled cycle is a valley strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces gates off and the carrier to the valley |
| half_period | input | 12 | Carrier peak count P (0 treated as 1) |
| dead_time | input | 8 | Dead band in clocks (gap is dead_time+1) |
| vdc_ref | input | 12 | Nominal DC-link voltage |
| vdc_meas | input | 12 | Measured DC-link voltage |
| vref | input | 36 | Three signed 12-bit phase demands, phase 0 in the low bits |
| gate_hi | output | 3 | High-side gate per phase |
| gate_lo | output | 3 | Low-side gate per phase |
| sample_stb | output | 1 | Valley/peak strobe |
| carrier | output | 12 | Carrier count |

## Verification
The carrier and the strobe are combinational functions of registered state and appear in the cycle after each edge. A demand applied before edge k lands in the shadow at edge k. It reaches the active register at the first strobe-ending edge after that, and it changes the gates one edge later, followed by the dead band. The bench keeps a cycle-stepped model that advances at every rising edge on the inputs sampled there and queues the expected carrier and gate values. A monitor compares them at the following falling edge. Directed checks measure dead-band lengths and the suppression of short pulses in the same falling-edge slot.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic {
    CNT_UP = 1'b0,
    CNT_DN = 1'b1
  } cdir_t;
endpackage

// File: rtl/dpwm_carrier.sv
module dpwm_carrier
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] peak,
  output logic [CNT_W-1:0] cnt,
  output logic             evt
);
  cdir_t dir;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      dir <= CNT_UP;
    end else begin
      case (dir)
        CNT_UP: begin
          if (cnt >= peak) begin
            dir <= CNT_DN;
            cnt <= cnt - CNT_W'(1);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            dir <= CNT_UP;
            cnt <= CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign evt = (cnt == '0) || (cnt == peak);
endmodule

// File: rtl/dpwm_ref_scaler.sv
module dpwm_ref_scaler #(
  parameter int REF_W   = 12,
  parameter int DC_W    = 12,
  parameter int CNT_W   = 12,
  parameter int VDC_MIN = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [DC_W-1:0]         vdc_ref,
  input  logic [DC_W-1:0]         vdc_meas,
  input  logic [CNT_W-1:0]        peak,
  output logic [CNT_W-1:0]        shadow
);
  localparam int PW    = REF_W + DC_W + 1;
  localparam int MW    = PW + CNT_W + 1;
  localparam int HALFI = 1 << (REF_W - 1);

  logic                 use_gain;
  logic signed [PW-1:0] refx, vrx, den, prod, quot, scaled, offs;
  logic signed [MW-1:0] offx, pkx, wide, mapped;
  logic [CNT_W-1:0]     clamped;

  assign use_gain = (vdc_meas >= DC_W'(VDC_MIN));
  assign refx     = {{(PW-REF_W){ref_in[REF_W-1]}}, ref_in};
  assign vrx      = $signed({{(PW-DC_W){1'b0}}, vdc_ref});
  assign den      = use_gain ? $signed({{(PW-DC_W){1'b0}}, vdc_meas}) : $signed(PW'(1));
  assign prod     = refx * vrx;
  assign quot     = prod / den;
  assign scaled   = use_gain ? quot : refx;
  assign offs     = scaled + $signed(PW'(HALFI));
  assign offx     = {{(MW-PW){offs[PW-1]}}, offs};
  assign pkx      = $signed({{(MW-CNT_W){1'b0}}, peak});
  assign wide     = offx * pkx;
  assign mapped   = wide >>> REF_W;

  always_comb begin
    if (mapped < 0)        clamped = '0;
    else if (mapped > pkx) clamped = peak;
    else                   clamped = mapped[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) shadow <= '0;
    else     shadow <= clamped;
  end
endmodule

// File: rtl/dpwm_deadband.sv
module dpwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [DT_W-1:0] dead_time,
  input  logic            demand,
  output logic            hi,
  output logic            lo
);
  logic            want;
  logic [DT_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      want  <= 1'b0;
      timer <= '0;
      hi    <= 1'b0;
      lo    <= 1'b0;
    end else if (demand != want) begin
      want  <= demand;
      timer <= dead_time;
      hi    <= 1'b0;
      lo    <= 1'b0;
    end else if (timer != '0) begin
      timer <= timer - DT_W'(1);
      hi    <= 1'b0;
      lo    <= 1'b0;
    end else begin
      hi <= want;
      lo <= !want;
    end
  end
endmodule

// File: rtl/dpwm_modulator.sv
module dpwm_modulator #(
  parameter int PH      = 3,
  parameter int REF_W   = 12,
  parameter int DC_W    = 12,
  parameter int CNT_W   = 12,
  parameter int DT_W    = 8,
  parameter int VDC_MIN = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [CNT_W-1:0]      half_period,
  input  logic [DT_W-1:0]       dead_time,
  input  logic [DC_W-1:0]       vdc_ref,
  input  logic [DC_W-1:0]       vdc_meas,
  input  logic [PH*REF_W-1:0]   vref,
  output logic [PH-1:0]         gate_hi,
  output logic [PH-1:0]         gate_lo,
  output logic                  sample_stb,
  output logic [CNT_W-1:0]      carrier
);
  logic [CNT_W-1:0] peak;
  logic             evt;

  assign peak = (half_period == '0) ? CNT_W'(1) : half_period;

  dpwm_carrier #(.CNT_W(CNT_W)) u_car (
    .clk(clk), .rst(rst), .en(en), .peak(peak), .cnt(carrier), .evt(evt)
  );

  assign sample_stb = en && !rst && evt;

  for (genvar k = 0; k < PH; k++) begin : g_leg
    logic [CNT_W-1:0] shadow;
    logic [CNT_W-1:0] active;
    logic             demand;

    dpwm_ref_scaler #(
      .REF_W(REF_W), .DC_W(DC_W), .CNT_W(CNT_W), .VDC_MIN(VDC_MIN)
    ) u_scl (
      .clk(clk), .rst(rst),
      .ref_in($signed(vref[k*REF_W +: REF_W])),
      .vdc_ref(vdc_ref), .vdc_meas(vdc_meas), .peak(peak),
      .shadow(shadow)
    );

    always_ff @(posedge clk) begin
      if (rst || !en)  active <= '0;
      else if (evt)    active <= shadow;
    end

    assign demand = (active > carrier);

    dpwm_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst(rst), .en(en), .dead_time(dead_time),
      .demand(demand), .hi(gate_hi[k]), .lo(gate_lo[k])
    );
  end
endmodule

// File: rtl/dpwm_modulator_chk.sv
module dpwm_modulator_chk #(
  parameter int PH    = 3,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [CNT_W-1:0] half_period,
  input logic [PH-1:0]    gate_hi,
  input logic [PH-1:0]    gate_lo,
  input logic             sample_stb,
  input logic [CNT_W-1:0] carrier
);
  logic [CNT_W-1:0] hp_eff;
  assign hp_eff = (half_period == '0) ? CNT_W'(1) : half_period;

  // R1: carrier moves by exactly one per enabled clock
  p_carrier_step_r1: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(rst)) |->
      (({1'b0, carrier} == {1'b0, $past(carrier)} + (CNT_W+1)'(1)) ||
       ({1'b0, carrier} + (CNT_W+1)'(1) == {1'b0, $past(carrier)})));

  // R1: carrier stays within 0..P while P is steady
  p_carrier_range_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && en && $stable(half_period) && ($past(carrier) <= hp_eff)) |->
      (carrier <= hp_eff));

  // R2: strobe only at valley or peak while enabled
  p_strobe_pos_r2: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (en && ((carrier == '0) || (carrier == hp_eff))));

  // R9: disabled block is idle one clock later
  p_disable_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((gate_hi == '0) && (gate_lo == '0) && (carrier == '0)));

  for (genvar k = 0; k < PH; k++) begin : g_chk
    // R7: never both gates of a leg
    p_gate_excl_r7: assert property (@(posedge clk) disable iff (rst)
      !(gate_hi[k] && gate_lo[k]));
    // R7: no direct handover from low side to high side
    p_no_direct_on_r7: assert property (@(posedge clk) disable iff (rst)
      gate_hi[k] |-> !$past(gate_lo[k]));
    // R7: high side stays off in the cycle the low side releases
    p_gap_after_fall_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(gate_lo[k]) |-> !gate_hi[k]);
  end
endmodule

bind dpwm_modulator dpwm_modulator_chk #(.PH(PH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .half_period(half_period),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .sample_stb(sample_stb),
  .carrier(carrier)
);

// File: tb/sim_dpwm_modulator.sv
module sim_dpwm_modulator;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, en = 1'b0;
  logic [11:0] half_period = 12'd20;
  logic [7:0]  dead_time = 8'd2;
  logic [11:0] vdc_ref = 12'd2000, vdc_meas = 12'd2000;
  logic signed [11:0] ra = '0, rb = '0, rc = '0;
  logic [2:0] gate_hi, gate_lo;
  logic sample_stb;
  logic [11:0] carrier;

  dpwm_modulator u0 (
    .clk(clk), .rst(rst), .en(en), .half_period(half_period),
    .dead_time(dead_time), .vdc_ref(vdc_ref), .vdc_meas(vdc_meas),
    .vref({rc, rb, ra}), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .sample_stb(sample_stb), .carrier(carrier)
  );

  int errors = 0, checks = 0;
  string tag = "R6";

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model from R4 and R5
  function automatic longint map_ref(longint r, longint vr, longint vm, longint pk);
    longint s;
    s = (vm >= 64) ? (r * vr) / vm : r;
    s = ((s + 2048) * pk) >>> 12;
    if (s < 0) s = 0;
    if (s > pk) s = pk;
    return s;
  endfunction

  typedef struct { int cnt; logic [2:0] hi; logic [2:0] lo; } exp_t;
  exp_t q[$];

  int m_cnt = 0; logic m_dn = 0;
  longint m_sh[3], m_act[3];
  int m_tmr[3];
  logic [2:0] m_want = 0, m_hi = 0, m_lo = 0;
  initial for (int i = 0; i < 3; i++) begin m_sh[i] = 0; m_act[i] = 0; m_tmr[i] = 0; end

  // Driver-side model: steps on each rising edge and queues expected outputs
  always @(posedge clk) begin
    longint nsh[3];
    longint r[3];
    int pk; logic ev; logic d;
    exp_t e;
    r[0] = longint'(ra); r[1] = longint'(rb); r[2] = longint'(rc);
    pk = (half_period == 0) ? 1 : int'(half_period);
    if (rst) begin
      m_cnt = 0; m_dn = 0; m_want = 0; m_hi = 0; m_lo = 0;
      for (int i = 0; i < 3; i++) begin m_sh[i] = 0; m_act[i] = 0; m_tmr[i] = 0; end
    end else begin
      for (int i = 0; i < 3; i++) nsh[i] = map_ref(r[i], vdc_ref, vdc_meas, pk);
      if (!en) begin
        m_cnt = 0; m_dn = 0; m_want = 0; m_hi = 0; m_lo = 0;
        for (int i = 0; i < 3; i++) begin m_act[i] = 0; m_tmr[i] = 0; end
      end else begin
        ev = (m_cnt == 0) || (m_cnt == pk);
        for (int i = 0; i < 3; i++) begin
          d = (m_act[i] > m_cnt);
          if (d != m_want[i]) begin
            m_want[i] = d; m_tmr[i] = int'(dead_time); m_hi[i] = 0; m_lo[i] = 0;
          end else if (m_tmr[i] != 0) begin
            m_tmr[i]--; m_hi[i] = 0; m_lo[i] = 0;
          end else begin
            m_hi[i] = m_want[i]; m_lo[i] = !m_want[i];
          end
          if (ev) m_act[i] = m_sh[i];
        end
        if (!m_dn) begin
          if (m_cnt >= pk) begin m_dn = 1; m_cnt--; end else m_cnt++;
        end else begin
          if (m_cnt == 0) begin m_dn = 0; m_cnt = 1; end else m_cnt--;
        end
      end
      for (int i = 0; i < 3; i++) m_sh[i] = nsh[i];
    end
    e.cnt = m_cnt; e.hi = m_hi; e.lo = m_lo;
    q.push_back(e);
  end

  // Monitor: pops and compares at the falling edge
  logic gap_chk = 0;
  int last_on = 0, lowrun = 0;
  always @(negedge clk) begin
    exp_t e;
    int pk; logic stb_e; int cur;
    if (q.size() > 0) begin
      e = q.pop_front();
      pk = (half_period == 0) ? 1 : int'(half_period);
      stb_e = en && !rst && ((e.cnt == 0) || (e.cnt == pk));
      chk(int'(carrier) == e.cnt, {"R1 carrier ", tag}, carrier, e.cnt);
      chk(sample_stb == stb_e, {"R2 strobe ", tag}, sample_stb, stb_e);
      chk(gate_hi == e.hi, {"R6 gate_hi ", tag}, gate_hi, e.hi);
      chk(gate_lo == e.lo, {"R7 gate_lo ", tag}, gate_lo, e.lo);
    end
    if (!gap_chk) begin
      last_on = 0; lowrun = 0;
    end else if (gate_hi[0] || gate_lo[0]) begin
      cur = gate_hi[0] ? 1 : 2;
      if (last_on != 0 && last_on != cur)
        chk(lowrun == int'(dead_time) + 1, "R7 dead gap length", lowrun, int'(dead_time) + 1);
      last_on = cur; lowrun = 0;
    end else lowrun++;
  end

  task automatic drive_slot();
    @(posedge clk); #2;
  endtask

  task automatic run(input int n);
    repeat (n) drive_slot();
  endtask

  initial begin
    int hcount;
    run(4);
    // R9: reset state
    @(negedge clk);
    chk(gate_hi == 0 && gate_lo == 0, "R9 gates in reset", {gate_hi, gate_lo}, 0);
    chk(carrier == 0 && !sample_stb, "R9 carrier in reset", carrier, 0);
    drive_slot(); rst = 0; en = 1;
    @(negedge clk);
    chk(sample_stb == 1 && carrier == 0, "R9 first enabled valley strobe", sample_stb, 1);
    // R5: zero demand, unity gain
    tag = "R5 mid"; run(200);
    // R7: long pulses, measure dead gaps
    tag = "R7 gaps"; ra = 12'sd1000; rb = -12'sd1000; rc = 12'sd2047;
    run(5); gap_chk = 1; run(300); gap_chk = 0;
    // R4: gain 2 with clamping
    tag = "R4 gain"; vdc_meas = 12'd1000; ra = 12'sd700; rb = -12'sd1500; run(200);
    // R4: measured voltage below the minimum and zero
    tag = "R4 low vdc"; vdc_meas = 12'd30; run(120);
    vdc_meas = 12'd0; run(120);
    vdc_meas = 12'd2600; run(120);
    // R3: demands changing mid half-period
    tag = "R3 mid change";
    for (int i = 0; i < 40; i++) begin
      ra = 12'(i * 97 - 1900); rb = 12'(1800 - i * 61); rc = 12'(i * 13); run(7);
    end
    // R8: one-clock demand pulses shorter than the dead band
    tag = "R8 short pulse"; vdc_meas = 12'd2000; dead_time = 8'd30;
    ra = -12'sd1700; run(100);
    hcount = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (gate_hi[0]) hcount++;
    end
    chk(hcount == 0, "R8 high side never on", hcount, 0);
    drive_slot();
    // R9: enable low then high again
    tag = "R9 enable"; dead_time = 8'd2; ra = 12'sd500; run(50);
    en = 0; @(negedge clk); @(negedge clk);
    chk(gate_hi == 0 && gate_lo == 0 && carrier == 0, "R9 disabled idle", {gate_hi, gate_lo, carrier}, 0);
    drive_slot(); en = 1; run(100);
    // R1: zero half-period acts as one; dead time zero
    tag = "R1 tiny period"; half_period = 12'd0; dead_time = 8'd0; run(60);
    half_period = 12'd3; run(60);
    tag = "R6 final"; half_period = 12'd50; ra = 12'sd300; rb = -12'sd300; rc = 12'sd0; run(300);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule